// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small processor with one accumulator. It runs programs held in a byte-addressed memory and reaches that memory through a single synchronous port that moves one byte at a time. Every instruction passes through the same fixed sequence: the instruction is read, the program counter is advanced, the instruction is decoded, an operand is read if the opcode needs one, and the instruction is executed. The architectural state is a program counter, an instruction register, an address register and an accumulator.

An instruction is a 32-bit word stored most-significant byte first. Bits 31:24 hold the opcode and bits 23:0 hold an absolute byte address. During decode the address field is copied into the address register. The block has three working opcodes: add, store and unconditional jump. It also has a halt opcode. Any opcode it does not know stops the processor and raises an error flag. The widths, the opcode values and the adder structure are parameters.

Top module: `acc_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, instruction register, address register, accumulator, carry and illegal flags. While reset is held and in the first cycle after it, the block asserts a read of address 0 and holds `halted` low.
- R2: An instruction fetch makes four single-byte reads at the program counter plus 0, 1, 2 and 3. Each byte is taken from `mem_rdata` one cycle after its address is presented. The first byte read becomes bits 31:24 of the instruction, which is the opcode.
- R3: Opcode 0x40 reads a 32-bit operand as four bytes, most-significant first, starting at the address field. It adds the operand to the accumulator, and the sum wraps modulo 2^32.
- R4: `carry` holds the carry out of the most recent add. No other instruction changes it.
- R5: Opcode 0x35 writes the accumulator to the address field and the next three addresses, most-significant byte first. It leaves the accumulator unchanged.
- R6: Opcode 0x00 loads the program counter with the address field, so the next fetch starts there. It leaves the accumulator unchanged.
- R7: After each fetch the program counter advances by 4 modulo 2^24, so a fetch at 0xFFFFFC is followed by a fetch at 0.
- R8: Opcode 0xFF sets `halted` and leaves `illegal` low. Once `halted` is set it stays set until reset, and the port makes no further reads or writes.
- R9: Any opcode other than 0x00, 0x35, 0x40 or 0xFF sets both `halted` and `illegal`. It performs no memory access and no register update.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 24 | Byte address for the current transfer |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte being stored |
| mem_rdata | input | 8 | Byte returned by the memory one cycle after a read |
| halted | output | 1 | Processor has stopped |
| illegal | output | 1 | Stop was caused by an unknown opcode |
| carry | output | 1 | Carry out of the last add |

## Verification
The assertions check the port-level rules on every cycle:
- read and write are never high together;
- a halted core stays silent and stays halted, and the illegal flag implies halted;
- the carry moves only in cycles that follow a cycle with no memory transfer;
- the port's state right after reset.

The arithmetic itself can only be shown by the bench's programs, which read results back through stores. These programs cover big-endian byte order, wrapping sums and their carry, the jump target and the skipped instruction it passes over, an accumulator that survives stores and jumps, the program counter wrapping at the top of the 24-bit space, and the absence of side effects after an unknown opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH_A,
      ST_FETCH_D,
      ST_INCR,
      ST_DECODE,
      ST_OPND_A,
      ST_OPND_D,
      ST_EXEC,
      ST_STORE,
      ST_HALT
   } cpu_state_e;

   localparam logic [7:0] DEF_OPC_JUMP  = 8'h00;
   localparam logic [7:0] DEF_OPC_STORE = 8'h35;
   localparam logic [7:0] DEF_OPC_ADD   = 8'h40;
   localparam logic [7:0] DEF_OPC_HALT  = 8'hFF;

endpackage

// File: rtl/acc_shiftin.sv
// Byte assembler: shifts bytes in at the low end, so the first byte
// received ends up most significant (big-endian accumulation).
module acc_shiftin #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] word
);

   localparam int KEEP_W = WORD_W - BYTE_W;

   always_ff @(posedge clk) begin
      if (rst)
         word <= '0;
      else if (shift_en)
         word <= {word[KEEP_W-1:0], byte_in};
   end

endmodule

// File: rtl/acc_adder.sv
// Accumulator adder. STYLE 0: single wide add; STYLE 1: byte-sliced ripple.
module acc_adder #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int STYLE  = 0
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] sum,
   output logic              cout
);

   localparam int NSLICE = WORD_W / BYTE_W;

   if (STYLE == 0) begin : g_wide
      assign {cout, sum} = {1'b0, a} + {1'b0, b};
   end else begin : g_ripple
      logic [NSLICE:0] c;
      assign c[0] = 1'b0;
      for (genvar g = 0; g < NSLICE; g++) begin : g_slice
         assign {c[g+1], sum[g*BYTE_W +: BYTE_W]} =
            {1'b0, a[g*BYTE_W +: BYTE_W]} +
            {1'b0, b[g*BYTE_W +: BYTE_W]} +
            {{BYTE_W{1'b0}}, c[g]};
      end
      assign cout = c[NSLICE];
   end

endmodule

// File: rtl/acc_ctrl.sv
// Sequencer: state and byte index for the fetch/increment/decode/operand/execute cycle.
module acc_ctrl
   import acc_pkg::*;
#(
   parameter int              OP_W      = 8,
   parameter int              NBYTES    = 4,
   parameter logic [OP_W-1:0] OPC_JUMP  = DEF_OPC_JUMP,
   parameter logic [OP_W-1:0] OPC_STORE = DEF_OPC_STORE,
   parameter logic [OP_W-1:0] OPC_ADD   = DEF_OPC_ADD,
   parameter logic [OP_W-1:0] OPC_HALT  = DEF_OPC_HALT,
   localparam int             IDX_W     = $clog2(NBYTES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OP_W-1:0]  opcode,
   output cpu_state_e       state,
   output logic [IDX_W-1:0] idx,
   output logic             illegal
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

   logic last;
   assign last = (idx == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_FETCH_A;
         idx     <= '0;
         illegal <= 1'b0;
      end else begin
         case (state)
            ST_FETCH_A: state <= ST_FETCH_D;
            ST_FETCH_D: begin
               idx   <= last ? '0 : idx + 1'b1;
               state <= last ? ST_INCR : ST_FETCH_A;
            end
            ST_INCR:    state <= ST_DECODE;
            ST_DECODE: begin
               if (opcode == OPC_ADD)
                  state <= ST_OPND_A;
               else if (opcode == OPC_STORE)
                  state <= ST_STORE;
               else if (opcode == OPC_JUMP)
                  state <= ST_EXEC;
               else begin
                  state   <= ST_HALT;
                  illegal <= (opcode != OPC_HALT);
               end
            end
            ST_OPND_A:  state <= ST_OPND_D;
            ST_OPND_D: begin
               idx   <= last ? '0 : idx + 1'b1;
               state <= last ? ST_EXEC : ST_OPND_A;
            end
            ST_EXEC:    state <= ST_FETCH_A;
            ST_STORE: begin
               idx   <= last ? '0 : idx + 1'b1;
               state <= last ? ST_FETCH_A : ST_STORE;
            end
            default:    state <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int              ADDR_W       = 24,
   parameter int              WORD_W       = 32,
   parameter int              OP_W         = 8,
   parameter int              BYTE_W       = 8,
   parameter int              ADDER_STYLE  = 1,
   parameter logic [OP_W-1:0] OPC_JUMP     = DEF_OPC_JUMP,
   parameter logic [OP_W-1:0] OPC_STORE    = DEF_OPC_STORE,
   parameter logic [OP_W-1:0] OPC_ADD      = DEF_OPC_ADD,
   parameter logic [OP_W-1:0] OPC_HALT     = DEF_OPC_HALT
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              halted,
   output logic              illegal,
   output logic              carry
);

   localparam int NBYTES = WORD_W / BYTE_W;
   localparam int IDX_W  = $clog2(NBYTES);

   if (OP_W + ADDR_W != WORD_W) begin : g_bad_split
      $error("opcode and address fields must fill the instruction word");
   end
   if (WORD_W % BYTE_W != 0 || NBYTES < 2) begin : g_bad_bytes
      $error("word must be at least two whole bytes");
   end
   if (ADDER_STYLE < 0 || ADDER_STYLE > 1) begin : g_bad_style
      $error("ADDER_STYLE must be 0 or 1");
   end

   cpu_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] ir;
   logic [WORD_W-1:0] opnd;
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] sum;
   logic              cout;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] ar;
   logic [OP_W-1:0]   opcode;

   assign opcode = ir[WORD_W-1 -: OP_W];

   acc_ctrl #(
      .OP_W      (OP_W),
      .NBYTES    (NBYTES),
      .OPC_JUMP  (OPC_JUMP),
      .OPC_STORE (OPC_STORE),
      .OPC_ADD   (OPC_ADD),
      .OPC_HALT  (OPC_HALT)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .opcode  (opcode),
      .state   (state),
      .idx     (idx),
      .illegal (illegal)
   );

   acc_shiftin #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ir (
      .clk      (clk),
      .rst      (rst),
      .shift_en (state == ST_FETCH_D),
      .byte_in  (mem_rdata),
      .word     (ir)
   );

   acc_shiftin #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_opnd (
      .clk      (clk),
      .rst      (rst),
      .shift_en (state == ST_OPND_D),
      .byte_in  (mem_rdata),
      .word     (opnd)
   );

   acc_adder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .STYLE(ADDER_STYLE)) u_add (
      .a    (acc),
      .b    (opnd),
      .sum  (sum),
      .cout (cout)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc    <= '0;
         ar    <= '0;
         acc   <= '0;
         carry <= 1'b0;
      end else begin
         case (state)
            ST_INCR:   pc <= pc + ADDR_W'(NBYTES);
            ST_DECODE: ar <= ir[ADDR_W-1:0];
            ST_EXEC: begin
               if (opcode == OPC_ADD) begin
                  acc   <= sum;
                  carry <= cout;
               end else if (opcode == OPC_JUMP) begin
                  pc <= ar;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_rd = 1'b0;
      mem_wr = 1'b0;
      case (state)
         ST_FETCH_A: begin
            mem_addr = pc + ADDR_W'(idx);
            mem_rd   = 1'b1;
         end
         ST_OPND_A: begin
            mem_addr = ar + ADDR_W'(idx);
            mem_rd   = 1'b1;
         end
         ST_STORE: begin
            mem_addr = ar + ADDR_W'(idx);
            mem_wr   = 1'b1;
         end
         default: mem_addr = pc;
      endcase
      mem_wdata = acc[(NBYTES - 1 - int'(idx)) * BYTE_W +: BYTE_W];
   end

   assign halted = (state == ST_HALT);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              halted,
   input logic              illegal,
   input logic              carry
);

   p_port_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_rd && !mem_wr));

   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   p_illegal_halts_r9: assert property (@(posedge clk) disable iff (rst)
      illegal |-> halted);

   p_illegal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      illegal |=> illegal);

   p_carry_exec_only_r4: assert property (@(posedge clk) disable iff (rst)
      !$stable(carry) |-> $past(!mem_rd && !mem_wr));

   p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_rd && mem_addr == '0 && !halted && !illegal && !carry));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_acc_core_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .halted   (halted),
   .illegal  (illegal),
   .carry    (carry)
);

// File: tb/test_acc_core.sv
module test_acc_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        halted, illegal, carry;

   always #5 clk = ~clk;

   acc_core i_acc_core (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .illegal   (illegal),
      .carry     (carry)
   );

   // behavioural memory, 1 KiB window, with a bench load path
   logic [7:0] mem [0:1023];
   logic       ld_we = 1'b0;
   logic [9:0] ld_addr = '0;
   logic [7:0] ld_data = '0;

   always @(posedge clk) begin
      if (ld_we)
         mem[ld_addr] <= ld_data;
      else if (mem_wr)
         mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_rd)
         mem_rdata <= mem[mem_addr[9:0]];
   end

   // port monitor
   int          wr_cnt, quiet_bad;
   logic        seen_wr, got_rd;
   logic [23:0] rd_after_wr;
   always @(posedge clk) begin
      if (rst) begin
         wr_cnt <= 0; quiet_bad <= 0; seen_wr <= 1'b0; got_rd <= 1'b0; rd_after_wr <= '0;
      end else begin
         if (mem_wr) begin wr_cnt <= wr_cnt + 1; seen_wr <= 1'b1; end
         if (halted && (mem_rd || mem_wr)) quiet_bad <= quiet_bad + 1;
         if (mem_rd && seen_wr && !got_rd) begin got_rd <= 1'b1; rd_after_wr <= mem_addr; end
      end
   end

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic poke(input logic [23:0] a, input logic [7:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = a[9:0]; ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic put_word(input logic [23:0] a, input logic [31:0] w);
      for (int i = 0; i < 4; i++) poke(a + 24'(i), w[31 - 8*i -: 8]);
   endtask

   task automatic put_ins(input logic [23:0] a, input logic [7:0] op, input logic [23:0] f);
      put_word(a, {op, f});
   endtask

   function automatic logic [31:0] peek_word(input logic [23:0] a);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) w[31 - 8*i -: 8] = mem[10'(a + 24'(i))];
      return w;
   endfunction

   task automatic hold_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // reset state check then release (R1)
   task automatic release_reset();
      @(negedge clk);
      chk("R1 rd during reset", 32'(mem_rd), 32'd1);
      chk("R1 addr during reset", 32'(mem_addr), 32'd0);
      chk("R1 flags during reset", {29'd0, halted, illegal, carry}, 32'd0);
      rst = 1'b0;
   endtask

   task automatic run_to_halt();
      int n = 0;
      while (!halted && n < 2000) begin @(negedge clk); n++; end
      chk("R8 halt reached", 32'(halted), 32'd1);
   endtask

   task automatic prog_add2(input logic [31:0] a, input logic [31:0] b);
      logic [32:0] s;
      hold_reset();
      put_ins(24'h000, 8'h40, 24'h000100);
      put_ins(24'h004, 8'h40, 24'h000104);
      put_ins(24'h008, 8'h35, 24'h000200);
      put_ins(24'h00C, 8'hFF, 24'h000000);
      put_word(24'h100, a);
      put_word(24'h104, b);
      put_word(24'h200, 32'h0);
      release_reset();
      run_to_halt();
      s = {1'b0, a} + {1'b0, b};
      chk("R3 sum", peek_word(24'h200), s[31:0]);
      chk("R4 carry", 32'(carry), 32'(s[32]));
      chk("R8 no illegal", 32'(illegal), 32'd0);
   endtask

   initial begin
      // R3/R4 sweep of add operands, including wrap and carry edges
      prog_add2(32'h0000_0000, 32'h0000_0000);
      prog_add2(32'h0000_0001, 32'h0000_0002);
      prog_add2(32'hFFFF_FFFF, 32'h0000_0001);
      prog_add2(32'h8000_0000, 32'h8000_0000);
      prog_add2(32'h1234_5678, 32'h9ABC_DEF0);
      prog_add2(32'h7FFF_FFFF, 32'h0000_0001);
      prog_add2(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      for (int k = 0; k < 4; k++)
         prog_add2(32'h0102_0304 << (k * 5), 32'hF0E0_D0C0 >> k);

      // R5: store leaves accumulator; R2 byte order visible in stored bytes
      hold_reset();
      put_ins(24'h000, 8'h40, 24'h000100);
      put_ins(24'h004, 8'h35, 24'h000200);
      put_ins(24'h008, 8'h35, 24'h000204);
      put_ins(24'h00C, 8'h40, 24'h000104);
      put_ins(24'h010, 8'h35, 24'h000208);
      put_ins(24'h014, 8'hFF, 24'h000000);
      put_word(24'h100, 32'hA1B2_C3D4);
      put_word(24'h104, 32'h0000_0010);
      release_reset();
      run_to_halt();
      chk("R5 first store", peek_word(24'h200), 32'hA1B2_C3D4);
      chk("R5 second store", peek_word(24'h204), 32'hA1B2_C3D4);
      chk("R5 acc after stores", peek_word(24'h208), 32'hA1B2_C3E4);
      chk("R2 msb byte first", 32'(mem[10'h200]), 32'hA1);
      chk("R5 write count", 32'(wr_cnt), 32'd12);

      // R6: jump skips an add and leaves the accumulator alone
      hold_reset();
      put_ins(24'h000, 8'h40, 24'h000100);
      put_ins(24'h004, 8'h00, 24'h000040);
      put_ins(24'h008, 8'h40, 24'h000104);
      put_ins(24'h040, 8'h35, 24'h000200);
      put_ins(24'h044, 8'hFF, 24'h000000);
      put_word(24'h100, 32'h0BAD_F00D);
      put_word(24'h104, 32'h1111_1111);
      release_reset();
      run_to_halt();
      chk("R6 jump target result", peek_word(24'h200), 32'h0BAD_F00D);
      chk("R6 single store", 32'(wr_cnt), 32'd4);

      // R8: halt is quiet and not illegal
      hold_reset();
      put_ins(24'h000, 8'hFF, 24'h000000);
      release_reset();
      run_to_halt();
      repeat (10) @(negedge clk);
      chk("R8 illegal low", 32'(illegal), 32'd0);
      chk("R8 still halted", 32'(halted), 32'd1);
      chk("R8 port quiet", 32'(quiet_bad + wr_cnt), 32'd0);

      // R9: unknown opcode halts, flags, no side effects
      hold_reset();
      put_ins(24'h000, 8'h40, 24'h000100);
      put_ins(24'h004, 8'h12, 24'h000200);
      put_ins(24'h008, 8'h35, 24'h000200);
      put_ins(24'h00C, 8'hFF, 24'h000000);
      put_word(24'h100, 32'h0000_0005);
      put_word(24'h200, 32'hDEAD_BEEF);
      release_reset();
      run_to_halt();
      repeat (10) @(negedge clk);
      chk("R9 illegal set", 32'(illegal), 32'd1);
      chk("R9 memory untouched", peek_word(24'h200), 32'hDEAD_BEEF);
      chk("R9 port quiet", 32'(quiet_bad + wr_cnt), 32'd0);

      // R7: program counter wraps from 0xFFFFFC to 0
      hold_reset();
      put_ins(24'h000, 8'h00, 24'hFFFFFC);
      put_ins(24'hFFFFFC, 8'h35, 24'h000200);
      release_reset();
      begin
         int n = 0;
         while (!got_rd && n < 2000) begin @(negedge clk); n++; end
      end
      chk("R7 fetch after wrap seen", 32'(got_rd), 32'd1);
      chk("R7 wrapped fetch address", 32'(rd_after_wr), 32'd0);
      chk("R7 not halted", 32'(halted), 32'd0);

      // R1: reset clears a halted, illegal state
      hold_reset();
      put_ins(24'h000, 8'hFF, 24'h000000);
      release_reset();
      run_to_halt();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule